// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block sits on the controller side of an outbound command ring. Software keeps 32-bit command words in a circular area of memory. It puts each new command into the slot after the current write pointer and then moves the write pointer register onto that slot. When the write pointer and the read pointer differ and the run bit is set, the engine steps its read pointer forward by one. It fetches the word at that slot through a single-request memory read port and presents the word on a valid/ready command output, with the target codec address split out.

A small register port lets software program the ring base, a size code, the write pointer, the run bit and the read pointer. The read pointer is never loaded directly. Software puts it into reset by writing the reset flag, confirms the reset by reading the flag back as 1, and leaves reset by writing zero, which reads back as zero. The ring is full when the next write slot would equal the read pointer. Software makes that judgement from the two pointers, so one slot always stays empty. While the controller is powered down, both pointer registers read as all ones, and software treats that value as an error.

Top module: `cmdring_engine`

## Requirements
- R1: After reset every register reads 0, and both `cmd_valid` and `mem_req` are low.
- R2: The size code in bits [1:0] of register 1 sets the ring depth: 0 gives 2 entries, 1 gives 16 entries, and 2 or 3 gives 256 entries. A write-pointer write keeps only the index bits for that depth.
- R3: With the run bit (register 0, bit 0) set and the read pointer not equal to the write pointer, the engine advances the read pointer by one, modulo the depth. It fetches from base + 4 × the new pointer. Right after a pointer reset, slot 0 is therefore skipped and slot 1 is fetched first.
- R4: At most one fetch is in flight. `mem_req` stays high with a stable address until `mem_gnt`. It is low while the engine waits for `mem_rvalid` and while a command is held on the output.
- R5: A fetched word is driven on `cmd_word`, and `cmd_codec` carries its bits [31:28]. Both stay stable with `cmd_valid` high until `cmd_ready`.
- R6: While the run bit is clear, no new fetch starts and the read pointer does not move.
- R7: Writing register 4 with bit 15 set clears the read pointer and enters reset. A readback then shows 0x8000 and no fetch starts. A following write of 0 leaves reset, the readback shows 0, and fetching resumes.
- R8: A write to register 4 with bit 15 clear, made while not in reset, leaves the read pointer unchanged.
- R9: While `pwr_down` is high, registers 3 (write pointer) and 4 (read pointer) read 0x0000FFFF. Other registers read normally.
- R10: The read pointer wraps from depth−1 to 0, so slot 0 is fetched after the last slot.
- R11: Fetching stops once the read pointer equals the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | Controller powered-down indication |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 size, 2 base, 3 write ptr, 4 read ptr) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address of the fetch |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_word | output | 32 | Command word |
| cmd_codec | output | 4 | Target codec address (bits 31:28 of the word) |

## Verification
The properties assume that the memory side returns exactly one `mem_rvalid` for each granted request, and only after the grant. The bench memory model registers the response one cycle after each grant, and it holds no state that could produce a stray response. They also assume that software does not rewrite pointers or the run bit in unusual orders. All register traffic in the bench follows the documented sequences: program the size before the pointers, and use the reset flag write, its readback, and the zero write. The consumer handshake is driven only on falling edges, so `cmd_ready` is stable when the design samples it.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] RA_SIZE = 3'd1;
    localparam logic [REG_AW-1:0] RA_BASE = 3'd2;
    localparam logic [REG_AW-1:0] RA_WPTR = 3'd3;
    localparam logic [REG_AW-1:0] RA_RPTR = 3'd4;

    localparam int          RP_RST_BIT = 15;
    localparam logic [15:0] PTR_DEAD   = 16'hFFFF;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2,
        FS_OUT  = 2'd3
    } fetch_state_e;
endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rp_adv,
    output logic              run,
    output logic              hold,
    output logic [ADDR_W-1:0] base,
    output logic [PTR_W-1:0]  wp,
    output logic [PTR_W-1:0]  rp,
    output logic [PTR_W-1:0]  rp_next
);
    localparam logic [PTR_W-1:0] MASK_SMALL = PTR_W'(1);
    localparam logic [PTR_W-1:0] MASK_MID   = PTR_W'(15);

    typedef struct packed {
        logic              run;
        logic [1:0]        size;
        logic [ADDR_W-1:0] base;
        logic [PTR_W-1:0]  wp;
        logic [PTR_W-1:0]  rp;
        logic              hold;
    } regs_t;

    regs_t q, d;
    logic [PTR_W-1:0] mask;
    logic [15:0]      rp_view;

    always_comb begin
        case (q.size)
            2'd0:    mask = MASK_SMALL;
            2'd1:    mask = MASK_MID;
            default: mask = '1;
        endcase
    end

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                RA_CTRL: d.run  = wdata[0];
                RA_SIZE: d.size = wdata[1:0];
                RA_BASE: d.base = {wdata[ADDR_W-1:2], 2'b00};
                RA_WPTR: d.wp   = wdata[PTR_W-1:0] & mask;
                default: ;
            endcase
        end
        if (wr_en && addr == RA_RPTR) begin
            if (wdata[RP_RST_BIT]) begin
                d.hold = 1'b1;
                d.rp   = '0;
            end else if (q.hold) begin
                d.hold = 1'b0;
            end
        end else if (rp_adv) begin
            d.rp = (q.rp + PTR_W'(1)) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rp_view                  = '0;
        rp_view[PTR_W-1:0]       = q.rp;
        rp_view[RP_RST_BIT]      = q.hold;
        rdata                    = '0;
        case (addr)
            RA_CTRL: rdata[0]            = q.run;
            RA_SIZE: rdata[1:0]          = q.size;
            RA_BASE: rdata[ADDR_W-1:0]   = q.base;
            RA_WPTR: rdata[15:0]         = pwr_down ? PTR_DEAD : 16'(q.wp);
            RA_RPTR: rdata[15:0]         = pwr_down ? PTR_DEAD : rp_view;
            default: rdata               = '0;
        endcase
    end

    assign run     = q.run;
    assign hold    = q.hold;
    assign base    = q.base;
    assign wp      = q.wp;
    assign rp      = q.rp;
    assign rp_next = (q.rp + PTR_W'(1)) & mask;
endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              hold,
    input  logic              ptr_ne,
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  rp_next,
    output logic              rp_adv,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [DATA_W-1:0] cmd_word
);
    localparam int OFS_W = PTR_W + 2;

    typedef struct packed {
        fetch_state_e      state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] word;
    } fetch_t;

    fetch_t q, d;
    logic [OFS_W-1:0] ofs;

    assign ofs = {rp_next, 2'b00};

    always_comb begin
        d      = q;
        rp_adv = 1'b0;
        case (q.state)
            FS_IDLE: begin
                if (run && !hold && ptr_ne) begin
                    d.state = FS_REQ;
                    d.addr  = base + ADDR_W'(ofs);
                end
            end
            FS_REQ: begin
                if (mem_gnt) begin
                    rp_adv  = 1'b1;
                    d.state = FS_WAIT;
                end
            end
            FS_WAIT: begin
                if (mem_rvalid) begin
                    d.word  = mem_rdata;
                    d.state = FS_OUT;
                end
            end
            FS_OUT: begin
                if (cmd_ready) d.state = FS_IDLE;
            end
            default: d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: FS_IDLE, addr: '0, word: '0};
        else        q <= d;
    end

    assign mem_req   = (q.state == FS_REQ);
    assign mem_addr  = q.addr;
    assign cmd_valid = (q.state == FS_OUT);
    assign cmd_word  = q.word;
endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [DATA_W-1:0] cmd_word,
    output logic [3:0]        cmd_codec
);
    logic              ctl_run;
    logic              rp_hold;
    logic              rp_adv;
    logic [ADDR_W-1:0] ring_base;
    logic [PTR_W-1:0]  wp;
    logic [PTR_W-1:0]  rp;
    logic [PTR_W-1:0]  rp_next;

    cmdring_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_down(pwr_down),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .rp_adv  (rp_adv),
        .run     (ctl_run),
        .hold    (rp_hold),
        .base    (ring_base),
        .wp      (wp),
        .rp      (rp),
        .rp_next (rp_next)
    );

    cmdring_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_run),
        .hold      (rp_hold),
        .ptr_ne    (wp != rp),
        .base      (ring_base),
        .rp_next   (rp_next),
        .rp_adv    (rp_adv),
        .mem_req   (mem_req),
        .mem_gnt   (mem_gnt),
        .mem_addr  (mem_addr),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_word  (cmd_word)
    );

    assign cmd_codec = cmd_word[DATA_W-1:DATA_W-4];
endmodule

// File: rtl/cmdring_engine_chk.sv
module cmdring_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              hold,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [DATA_W-1:0] cmd_word
);
    // R4
    single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    // R4
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R4
    out_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !mem_req);

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));

    // R6
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !mem_req) |=> !mem_req);

    // R7
    hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !mem_req) |=> !mem_req);
endmodule

bind cmdring_engine cmdring_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_run),
    .hold     (rp_hold),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_word (cmd_word)
);

// File: tb/cmdring_engine_tb.sv
module cmdring_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic        mem_gnt;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_word;
    logic [3:0]  cmd_codec;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] base_tb = 32'h0000_1000;
    logic [31:0] last_addr = '0;

    always #5 clk = ~clk;

    cmdring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .cmd_codec(cmd_codec)
    );

    function automatic logic [31:0] pat(input int idx);
        logic [7:0] i8;
        i8 = 8'(idx);
        return {i8[3:0] ^ 4'hA, 8'h3C, 12'h000, i8};
    endfunction

    // memory model: grant at once, data one cycle after the grant
    assign mem_gnt = mem_req;
    always @(posedge clk) begin
        mem_rvalid <= mem_req && mem_gnt;
        if (mem_req && mem_gnt) begin
            mem_rdata <= pat(int'(((mem_addr - base_tb) >> 2) & 32'hFF));
            last_addr <= mem_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic get_cmd(input int idx, input string req);
        logic [31:0] e;
        int waitc;
        e = pat(idx);
        waitc = 0;
        while (!cmd_valid && waitc < 100) begin @(negedge clk); waitc++; end
        chk(cmd_valid, req, 32'(cmd_valid), 32'd1);
        chk(cmd_word == e, req, cmd_word, e);
        chk(cmd_codec == e[31:28], {req, " codec"}, 32'(cmd_codec), 32'(e[31:28]));
        chk(last_addr == base_tb + 32'(idx * 4), {req, " addr"}, last_addr, base_tb + 32'(idx * 4));
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic idle_check(input int cycles, input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cmd_valid || mem_req) seen = 1'b1;
        end
        chk(!seen, req, 32'(seen), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R1 reg", v, 0);
        end
        chk(!cmd_valid && !mem_req, "R1 outputs", {cmd_valid, mem_req}, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        wr(3'd2, base_tb);
        wr(3'd1, 32'd2);
        wr(3'd0, 32'd1);
        wr(3'd3, 32'd3);
        for (int i = 1; i <= 3; i++) get_cmd(i, "R3 basic");
        idle_check(8, "R11 stop at wp");
        rd(3'd4, v);
        chk(v == 32'd3, "R11 rp", v, 3);
    endtask

    task automatic t_hold();
        logic [31:0] w;
        wr(3'd3, 32'd4);
        while (!cmd_valid) @(negedge clk);
        w = cmd_word;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_word == w, "R5 hold", cmd_word, w);
            chk(!mem_req, "R4 no second fetch", 32'(mem_req), 0);
        end
        get_cmd(4, "R5 take");
    endtask

    task automatic t_run();
        logic [31:0] v;
        wr(3'd0, 32'd0);
        wr(3'd3, 32'd6);
        idle_check(10, "R6 run clear");
        rd(3'd4, v);
        chk(v == 32'd4, "R6 rp frozen", v, 4);
        wr(3'd0, 32'd1);
        get_cmd(5, "R6 resume");
        get_cmd(6, "R6 resume");
    endtask

    task automatic t_rpreset();
        logic [31:0] v;
        wr(3'd4, 32'h8000);
        rd(3'd4, v);
        chk(v == 32'h8000, "R7 in reset", v, 32'h8000);
        wr(3'd3, 32'd2);
        idle_check(10, "R7 no fetch in reset");
        wr(3'd4, 32'h0);
        rd(3'd4, v);
        chk(v == 32'h0, "R7 out of reset", v, 0);
        get_cmd(1, "R3 slot0 skipped");
        get_cmd(2, "R7 resume");
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(3'd4, 32'h0055);
        rd(3'd4, v);
        chk(v == 32'd2, "R8 rp ignored", v, 2);
        idle_check(5, "R8 no fetch");
    endtask

    task automatic t_size16();
        logic [31:0] v;
        wr(3'd1, 32'd1);
        wr(3'd3, 32'h1F);
        rd(3'd3, v);
        chk(v == 32'h0F, "R2 wp masked 16", v, 32'h0F);
        for (int i = 3; i <= 15; i++) get_cmd(i, "R2 ring16");
        wr(3'd3, 32'd1);
        get_cmd(0, "R10 wrap16");
        get_cmd(1, "R10 wrap16");
        rd(3'd4, v);
        chk(v == 32'd1, "R10 rp16", v, 1);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd3);
        rd(3'd3, v);
        chk(v == 32'd1, "R2 wp masked 2", v, 1);
        idle_check(5, "R11 equal idle");
    endtask

    task automatic t_size256();
        logic [31:0] v;
        wr(3'd1, 32'd2);
        wr(3'd4, 32'h8000);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'h0);
        wr(3'd3, 32'd255);
        for (int i = 1; i <= 255; i++) get_cmd(i, "R2 ring256");
        wr(3'd3, 32'd0);
        get_cmd(0, "R10 wrap256");
        rd(3'd4, v);
        chk(v == 32'd0, "R10 rp256", v, 0);
    endtask

    task automatic t_pwr();
        logic [31:0] v;
        pwr_down = 1'b1;
        rd(3'd3, v);
        chk(v == 32'hFFFF, "R9 wp dead", v, 32'hFFFF);
        rd(3'd4, v);
        chk(v == 32'hFFFF, "R9 rp dead", v, 32'hFFFF);
        rd(3'd2, v);
        chk(v == base_tb, "R9 base normal", v, base_tb);
        @(negedge clk);
        pwr_down = 1'b0;
        rd(3'd4, v);
        chk(v == 32'd0, "R9 rp after", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold();
        t_run();
        t_rpreset();
        t_ignore();
        t_size16();
        t_size256();
        t_pwr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule